// File: doc/BRIEF.md
# Serial Boot-Loader Command Engine

This engine sits between a byte-wide serial receiver/transmitter pair and the on-chip program RAM. A host uses it to place a small program in RAM and then start it. Received bytes arrive on a valid/ready stream and are parsed as command frames. Each frame begins with a command byte. Some frames also carry a little-endian 16-bit address and a little-endian 16-bit byte count.

A download frame writes its payload to consecutive RAM locations through a synchronous write port. The frame is closed by one checksum byte. That byte is the 8-bit wraparound sum of every earlier byte of the frame. The engine answers each frame that expects an answer with a single status byte. The upper nibble of that byte echoes the command, and the lower nibble is 1 for success or 2 for an error. The run command sends no answer. It fires a one-clock start pulse carrying a fixed RAM entry address, and the engine then stays quiet until reset.

Top module: `bl_cmd_engine`

## Requirements
- R1: With the check command enabled (CHECK_EN=1), a command byte whose bits 7..3 are 00011 (18h..1Fh) has no further bytes, and the engine answers it with 11h.
- R2: A command byte with bits 7..3 equal to 00000 (00h..07h) is a download. It is followed by address low, address high, count low, count high, then exactly count data bytes, then one checksum byte. Data byte k is written to address+k with a single ram_we cycle, one clock after the byte is accepted.
- R3: When the checksum byte equals the 8-bit wraparound sum of all earlier frame bytes, the reply is {command[7:4], 1h}. For example, 00 90 09 02 00 01 02 9E is answered with 01h.
- R4: When the checksum byte does not match, the reply is {command[7:4], 2h}. Data already written is not retracted.
- R5: A command byte with bits 7..3 equal to 01000 (40h..47h) takes four header bytes, which are ignored. It produces no reply. exec_pulse is high for exactly one clock, starting one clock after the fourth header byte is accepted, with exec_addr equal to START_ADDR. After that, rx_ready stays low until reset.
- R6: Bits 2..0 of the command byte do not affect decoding.
- R7: Any other command byte is answered at once with {command[7:4], 2h}, and no further bytes are consumed for it.
- R8: A download whose count is 0 or greater than MAX_COUNT (default 512) is answered with the error reply right after the fourth header byte. It writes nothing to RAM. A count of exactly MAX_COUNT is accepted.
- R9: With CHECK_EN=0, command bytes 18h..1Fh are treated as unknown commands (R7), so 18h is answered with 12h.
- R10: A reply stays on tx_data with tx_valid high, unchanged, until tx_ready is sampled high. While it is pending, rx_ready is low.
- R11: After reset, rx_ready is high, and tx_valid, ram_we and exec_pulse are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Engine accepts a received byte |
| tx_data | output | 8 | Status reply byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter takes the reply |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| exec_pulse | output | 1 | One-clock start request for the loaded program |
| exec_addr | output | ADDR_W | Entry address of the loaded program |

## Verification
The hardest situations to reach from the ports are the count limits and the checksum wraparound. The bench sends a download whose count is exactly MAX_COUNT. This walks the write pointer across 512 locations and wraps the running sum many times. It also sends counts of 0 and MAX_COUNT+1, which must fail right after the header. A second instance built without the check command receives the same byte stream, so the R9 decode difference shows up on the very same frames. The held-reply case is reached by holding tx_ready low for several cycles while a byte waits to be sent.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_HDR, ST_DATA, ST_SUM, ST_HALT
  } bl_state_e;

  localparam logic [4:0] OP_CHECK = 5'b00011;
  localparam logic [4:0] OP_LOAD  = 5'b00000;
  localparam logic [4:0] OP_RUN   = 5'b01000;
  localparam logic [3:0] RS_OK    = 4'h1;
  localparam logic [3:0] RS_ERR   = 4'h2;
endpackage

// File: rtl/bl_sum_acc.sv
module bl_sum_acc (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       restart,
  input  logic [7:0] din,
  output logic [7:0] sum
);
  always_ff @(posedge clk) begin
    if (rst) sum <= '0;
    else if (take) sum <= restart ? din : sum + din;
  end
endmodule

// File: rtl/bl_ram_writer.sv
module bl_ram_writer #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              push,
  input  logic [7:0]        din,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= push;
      if (start) ptr_q <= base;
      else if (push) begin
        ram_addr  <= ptr_q;
        ram_wdata <= din;
        ptr_q     <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bl_reply_reg.sv
module bl_reply_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= din;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // R10
  reply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/bl_cmd_engine.sv
module bl_cmd_engine
  import bl_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              MAX_COUNT  = 512,
  parameter logic [ADDR_W-1:0] START_ADDR = 'h190,
  parameter bit              CHECK_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              exec_pulse,
  output logic [ADDR_W-1:0] exec_addr
);
  localparam int CNT_W = $clog2(MAX_COUNT + 1);

  bl_state_e         state_q, state_d;
  logic [7:0]        cmd_q;
  logic [7:0]        lo_q;
  logic [1:0]        hdr_idx;
  logic              run_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  rem_q;
  logic [7:0]        sum_q;
  logic              acc;
  logic [15:0]       cnt_full;
  logic              cnt_bad;
  logic [4:0]        opc;
  logic              reply_ld, start_wr, wr_go, fire;
  logic [7:0]        reply_byte;

  assign rx_ready  = (state_q != ST_HALT) && !tx_valid;
  assign acc       = rx_valid && rx_ready;
  assign exec_addr = START_ADDR;
  assign cnt_full  = {rx_data, lo_q};
  assign cnt_bad   = (cnt_full == 16'd0) || (cnt_full > 16'(MAX_COUNT));
  assign opc       = rx_data[7:3];

  always_comb begin
    state_d    = state_q;
    reply_ld   = 1'b0;
    reply_byte = '0;
    start_wr   = 1'b0;
    wr_go      = 1'b0;
    fire       = 1'b0;
    if (acc) begin
      unique case (state_q)
        ST_CMD: begin
          if (CHECK_EN && opc == OP_CHECK) begin
            reply_ld   = 1'b1;
            reply_byte = {rx_data[7:4], RS_OK};
          end else if (opc == OP_LOAD || opc == OP_RUN) begin
            state_d = ST_HDR;
          end else begin
            reply_ld   = 1'b1;
            reply_byte = {rx_data[7:4], RS_ERR};
          end
        end
        ST_HDR: begin
          if (hdr_idx == 2'd3) begin
            if (run_q) begin
              fire    = 1'b1;
              state_d = ST_HALT;
            end else if (cnt_bad) begin
              reply_ld   = 1'b1;
              reply_byte = {cmd_q[7:4], RS_ERR};
              state_d    = ST_CMD;
            end else begin
              start_wr = 1'b1;
              state_d  = ST_DATA;
            end
          end
        end
        ST_DATA: begin
          wr_go = 1'b1;
          if (rem_q == CNT_W'(1)) state_d = ST_SUM;
        end
        ST_SUM: begin
          reply_ld   = 1'b1;
          reply_byte = {cmd_q[7:4], (rx_data == sum_q) ? RS_OK : RS_ERR};
          state_d    = ST_CMD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_CMD;
      cmd_q      <= '0;
      lo_q       <= '0;
      hdr_idx    <= '0;
      run_q      <= 1'b0;
      base_q     <= '0;
      rem_q      <= '0;
      exec_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      exec_pulse <= fire;
      if (acc) begin
        case (state_q)
          ST_CMD: begin
            cmd_q   <= rx_data;
            hdr_idx <= '0;
            run_q   <= (opc == OP_RUN);
          end
          ST_HDR: begin
            hdr_idx <= hdr_idx + 2'd1;
            if (hdr_idx[0] == 1'b0) lo_q <= rx_data;
            if (hdr_idx == 2'd1) base_q <= ADDR_W'({rx_data, lo_q});
            if (hdr_idx == 2'd3) rem_q <= cnt_full[CNT_W-1:0];
          end
          ST_DATA: rem_q <= rem_q - 1'b1;
          default: ;
        endcase
      end
    end
  end

  bl_sum_acc u_sum (
    .clk(clk), .rst(rst), .take(acc), .restart(state_q == ST_CMD),
    .din(rx_data), .sum(sum_q)
  );

  bl_ram_writer #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .start(start_wr), .base(base_q), .push(wr_go),
    .din(rx_data), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  bl_reply_reg u_reply (
    .clk(clk), .rst(rst), .load(reply_ld), .din(reply_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  // R5
  exec_once_chk: assert property (@(posedge clk) disable iff (rst)
    exec_pulse |=> (!exec_pulse && !rx_ready));

  // R2
  no_wr_during_reply_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !tx_valid);

  // R3
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_data[3:0] == RS_OK || tx_data[3:0] == RS_ERR));
endmodule

// File: tb/bl_cmd_engine_tb_top.sv
module bl_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic tx_ready = 1'b1;
  logic rx_ready, tx_valid, ram_we, exec_pulse;
  logic [7:0] tx_data, ram_wdata;
  logic [15:0] ram_addr, exec_addr;
  logic rx_ready_n, tx_valid_n, ram_we_n, exec_pulse_n;
  logic [7:0] tx_data_n, ram_wdata_n;
  logic [15:0] ram_addr_n, exec_addr_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  rq[$];
  logic [7:0]  rq_n[$];
  string       rtag[$];
  logic [23:0] wq[$];
  bit   exec_expected = 1'b0;
  int   exec_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_cmd_engine dut_i (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .exec_pulse(exec_pulse), .exec_addr(exec_addr)
  );

  bl_cmd_engine #(.CHECK_EN(1'b0)) dut_nc_i (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready_n),
    .tx_data(tx_data_n), .tx_valid(tx_valid_n), .tx_ready(tx_ready),
    .ram_we(ram_we_n), .ram_addr(ram_addr_n), .ram_wdata(ram_wdata_n),
    .exec_pulse(exec_pulse_n), .exec_addr(exec_addr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference monitor, evaluated every clock away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (ram_we || ram_we_n) begin
        if (wq.size() == 0) chk(1'b0, "R8 unexpected write", {ram_addr, ram_wdata}, 0);
        else begin
          logic [23:0] w;
          w = wq.pop_front();
          chk({ram_addr, ram_wdata} == w, "R2 write addr/data", {ram_addr, ram_wdata}, w);
          chk(ram_we_n && {ram_addr_n, ram_wdata_n} == w, "R2 write (no-check build)",
              {ram_addr_n, ram_wdata_n}, w);
        end
      end
      if (tx_valid && tx_ready) begin
        if (rq.size() == 0) chk(1'b0, "R7 unexpected reply", tx_data, 0);
        else begin
          logic [7:0] e, en;
          string t;
          e = rq.pop_front(); en = rq_n.pop_front(); t = rtag.pop_front();
          chk(tx_data == e, t, tx_data, e);
          chk(tx_valid_n && tx_data_n == en, {t, " R9 no-check build"}, tx_data_n, en);
        end
      end
      if (tx_valid) chk(!rx_ready, "R10 rx_ready low while reply pending", rx_ready, 0);
      if (exec_pulse) begin
        exec_seen++;
        chk(exec_expected, "R5 exec pulse expected", exec_pulse, exec_expected);
        chk(exec_addr == 16'h0190, "R5 exec address", exec_addr, 16'h0190);
        chk(exec_pulse_n, "R5 exec pulse no-check build", exec_pulse_n, 1);
      end
    end
  end

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_reply(input logic [7:0] e, input logic [7:0] en, input string t);
    rq.push_back(e); rq_n.push_back(en); rtag.push_back(t);
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && (rq.size() != 0 || wq.size() != 0); i++) @(negedge clk);
    chk(rq.size() == 0 && wq.size() == 0, "R2 queues drained", rq.size() + wq.size(), 0);
  endtask

  task automatic download(input logic [7:0] cmd, input logic [15:0] addr, input int n,
                          input logic [7:0] seed, input bit corrupt, input string t);
    logic [7:0] s, d;
    bit good;
    logic [7:0] st;
    good = (n >= 1 && n <= 512);
    s = cmd + addr[7:0] + addr[15:8] + n[7:0] + n[15:8];
    if (good) begin
      for (int k = 0; k < n; k++) begin
        d = seed + 8'(k * 7);
        s = s + d;
        wq.push_back({16'(addr + 16'(k)), d});
      end
      st = corrupt ? 8'h2 : 8'h1;
    end else st = 8'h2;
    expect_reply({cmd[7:4], st[3:0]}, {cmd[7:4], st[3:0]}, t);
    send(cmd); send(addr[7:0]); send(addr[15:8]); send(n[7:0]); send(n[15:8]);
    if (good) begin
      for (int k = 0; k < n; k++) send(seed + 8'(k * 7));
      send(corrupt ? s ^ 8'h5A : s);
    end
    drain();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(rx_ready && !tx_valid && !ram_we && !exec_pulse, "R11 reset outputs",
        {rx_ready, tx_valid, ram_we, exec_pulse}, 4'b1000);

    // R1 / R9 communication check
    expect_reply(8'h11, 8'h12, "R1 check 18h");
    send(8'h18); drain();
    // R6 low bits ignored on check
    expect_reply(8'h11, 8'h12, "R6 check 1Fh");
    send(8'h1F); drain();

    // R3 worked example 00 90 09 02 00 01 02 9E -> 01
    wq.push_back({16'h0990, 8'h01}); wq.push_back({16'h0990 + 16'd1, 8'h02});
    expect_reply(8'h01, 8'h01, "R3 example download");
    send(8'h00); send(8'h90); send(8'h09); send(8'h02); send(8'h00);
    send(8'h01); send(8'h02); send(8'h9E);
    drain();

    // R2 / R6 download with low bits set
    download(8'h05, 16'h0100, 20, 8'h33, 1'b0, "R6 download 05h");
    // R4 bad checksum
    download(8'h00, 16'h0200, 5, 8'hC0, 1'b1, "R4 checksum mismatch");
    // R8 count limits
    download(8'h00, 16'h0300, 0, 8'h00, 1'b0, "R8 count zero");
    download(8'h02, 16'h0300, 513, 8'h00, 1'b0, "R8 count above limit");
    download(8'h00, 16'h0400, 512, 8'h5D, 1'b0, "R8 count at limit");

    // R7 unknown commands
    expect_reply(8'hA2, 8'hA2, "R7 unknown A5h");
    send(8'hA5); drain();
    expect_reply(8'h22, 8'h22, "R7 unknown 20h");
    send(8'h20); drain();
    expect_reply(8'h42, 8'h42, "R7 unknown 48h");
    send(8'h48); drain();

    // R10 reply held while transmitter stalls
    tx_ready = 1'b0;
    expect_reply(8'h11, 8'h12, "R10 stalled reply");
    send(8'h18);
    repeat (6) @(negedge clk);
    chk(tx_valid && tx_data == 8'h11, "R10 reply held", tx_data, 8'h11);
    chk(!rx_ready, "R10 backpressure", rx_ready, 0);
    tx_ready = 1'b1;
    drain();

    // R5 execute: no reply, single pulse, then halted
    exec_expected = 1'b1;
    send(8'h43); send(8'h12); send(8'h34); send(8'h56); send(8'h78);
    repeat (10) @(negedge clk);
    chk(exec_seen == 1, "R5 exactly one exec pulse", exec_seen, 1);
    chk(!rx_ready && !tx_valid, "R5 halted after exec", {rx_ready, tx_valid}, 0);
    rx_valid = 1'b1; rx_data = 8'h18;
    repeat (5) @(negedge clk);
    chk(!tx_valid && !rx_ready, "R5 input ignored after exec", tx_valid, 0);
    rx_valid = 1'b0;
    chk(rq.size() == 0 && wq.size() == 0, "R5 no leftover expectations", rq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule